// File: doc/BRIEF.md
# Scatter-gather descriptor walker

This block drives the memory-to-stream direction of a DMA channel. Given a starting descriptor address and a tail address, it walks a linked list of descriptors held in memory. For each descriptor it fetches the fields it needs over a word-wide request/response memory port and rejects a descriptor that is already marked complete. At start of frame it forwards five application words on a control stream. It then reads the described buffer and sends it as a data stream with byte enables and a last flag. Finally it writes a completion status back into the descriptor and follows the next pointer.

The walk stops in one of three ways. It goes idle after the descriptor at the tail address. It halts on a descriptor that was already complete. It halts with an error flag when a descriptor fetch fails. A new walk is launched by a single-cycle start pulse that carries both pointers. Each descriptor that closes a frame produces one frame-complete pulse.

A descriptor is 52 bytes, made of little-endian 32-bit words at byte offsets from its base. Offset 0 holds the next pointer (low word), offset 8 the buffer address (low word) and offset 24 the control word. Offset 28 holds the status word, and offsets 32 to 48 hold the application words. The upper halves of the 64-bit pointers and the reserved field are not fetched.

Top module: `sg_walker`

## Requirements
- R1: After synchronous reset, halted is 1 and idle, running, all error flags, frame_done, mem_req, ctl_valid and dat_valid are 0.
- R2: A start pulse while the walker is stopped loads both pointers, sets running, clears halted, idle and all error flags, and begins fetching at the start pointer. Without a start pulse the walker issues no memory request.
- R3: A descriptor is fetched as nine word reads at byte offsets 0, 8, 24, 28, 32, 36, 40, 44, 48 in that order. A request is held with a stable address until mem_ready.
- R4: If status bit 31 of a fetched descriptor is set, halted goes to 1 and running stays 1. No stream beat and no write-back follow.
- R5: When control bit 27 (start of frame) is set, the five application words go out on the control stream in offset order, with ctl_last on the fifth, before any data beat of that descriptor.
- R6: Control bits 22:0 give the byte length L. The buffer is sent as ceil(L/4) beats read at ascending word addresses from the buffer address. dat_keep is 4'hF on full words and has its low L mod 4 bits set on a partial final word. L = 0 sends no beat.
- R7: dat_last is 1 only on the final beat of a descriptor whose control bit 26 (end of frame) is set.
- R8: After the data, the walker writes 32'h8000_0000 (complete flag, zero residual) to the descriptor at offset 28.
- R9: After the write-back the walker moves to the next pointer. If the descriptor just finished sits at the tail address, idle goes to 1 and the walk stops.
- R10: A fetch response with code 2'b10 sets err_decode. Any other non-zero code sets err_slave. Either one clears running, sets halted and err_irq, and ends the walk without write-back.
- R11: frame_done is a single-cycle pulse, once for each end-of-frame descriptor, after its write-back completes.
- R12: The control and data streams are never valid together. A stalled beat keeps its data, keep and valid until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted while stopped |
| cur_ptr_in | input | ADDR_W | Address of the first descriptor |
| tail_ptr_in | input | ADDR_W | Address of the last descriptor |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Response valid, one per accepted request |
| mem_rdata | input | 32 | Read data |
| mem_rerr | input | 2 | Response code: 0 ok, 2 decode error, others slave error |
| ctl_valid | output | 1 | Control stream beat valid |
| ctl_ready | input | 1 | Control stream ready |
| ctl_data | output | 32 | Application word |
| ctl_last | output | 1 | Final application word |
| dat_valid | output | 1 | Data stream beat valid |
| dat_ready | input | 1 | Data stream ready |
| dat_data | output | 32 | Buffer word |
| dat_keep | output | 4 | Byte enables |
| dat_last | output | 1 | End of frame beat |
| running | output | 1 | Run flag |
| halted | output | 1 | Walker halted |
| idle | output | 1 | Tail reached |
| err_decode | output | 1 | Descriptor fetch decode error |
| err_slave | output | 1 | Descriptor fetch slave error |
| err_irq | output | 1 | Error interrupt |
| frame_done | output | 1 | Frame-complete pulse |

## Verification
The bench builds the walker with the default ADDR_W of 32 and places every descriptor and buffer inside a 1 KiB memory model, so any fetch offset and write-back address can be checked exactly. Memory, control-stream and data-stream ready each follow a different periodic pattern. This exercises held requests and stalled beats in every phase, including the partial final word and the zero-length descriptor. Error codes are injected at a chosen fetch address, which reaches both error flags mid-fetch, as well as the restart that clears them.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W   = 32;
  localparam int N_APP    = 5;
  localparam int N_FETCH  = 9;
  localparam int LEN_W    = 23;
  localparam int EOF_BIT  = 26;
  localparam int SOF_BIT  = 27;
  localparam int DONE_BIT = 31;
  localparam logic [3:0] STATUS_WOFF = 4'd7;
  localparam logic [1:0] RSP_OK     = 2'b00;
  localparam logic [1:0] RSP_DECERR = 2'b10;

  typedef enum logic [3:0] {
    S_STOP, S_F_REQ, S_F_WAIT, S_CHECK, S_CTL_LD, S_CTL_OUT,
    S_D_NEXT, S_D_REQ, S_D_WAIT, S_D_OUT, S_W_REQ, S_W_WAIT
  } walk_state_t;

  // word offset inside a descriptor for fetch step k
  function automatic logic [3:0] fetch_off(input logic [3:0] k);
    case (k)
      4'd0:    return 4'd0;
      4'd1:    return 4'd2;
      4'd2:    return 4'd6;
      4'd3:    return 4'd7;
      default: return 4'(k + 4'd4);
    endcase
  endfunction
endpackage

// File: rtl/sgw_app_ram.sv
module sgw_app_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 5
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sgw_beat_calc.sv
module sgw_beat_calc #(
  parameter int LEN_W = 23,
  parameter int BYTES = 4
) (
  input  logic [LEN_W-1:0] remain,
  output logic [BYTES-1:0] keep,
  output logic [LEN_W-1:0] take,
  output logic             final_beat
);
  localparam int BW = $clog2(BYTES);

  always_comb begin
    if (remain >= LEN_W'(BYTES)) begin
      keep       = '1;
      take       = LEN_W'(BYTES);
      final_beat = (remain == LEN_W'(BYTES));
    end else begin
      keep       = BYTES'((BYTES'(1) << remain[BW-1:0]) - BYTES'(1));
      take       = remain;
      final_beat = 1'b1;
    end
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cur_ptr_in,
  input  logic [ADDR_W-1:0] tail_ptr_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic [1:0]        mem_rerr,
  output logic              ctl_valid,
  input  logic              ctl_ready,
  output logic [31:0]       ctl_data,
  output logic              ctl_last,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [31:0]       dat_data,
  output logic [3:0]        dat_keep,
  output logic              dat_last,
  output logic              running,
  output logic              halted,
  output logic              idle,
  output logic              err_decode,
  output logic              err_slave,
  output logic              err_irq,
  output logic              frame_done
);
  localparam int APP_AW    = $clog2(N_APP);
  localparam int APP_FIRST = N_FETCH - N_APP;
  localparam int BYTES     = WORD_W / 8;
  localparam logic [WORD_W-1:0] DONE_WORD = WORD_W'(1) << DONE_BIT;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [3:0] woff);
    return base + ADDR_W'({woff, 2'b00});
  endfunction

  walk_state_t       state;
  logic [ADDR_W-1:0] cur_ptr, tail_ptr, nxt_ptr, buf_ptr;
  logic [LEN_W-1:0]  remain_q;
  logic              sof_q, eof_q, done_q;
  logic [3:0]        fetch_k;
  logic [APP_AW-1:0] app_idx;
  logic [WORD_W-1:0] dat_data_q;
  logic [BYTES-1:0]  dat_keep_q;
  logic              dat_last_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic              mem_we_q;
  logic [WORD_W-1:0] mem_wdata_q;
  logic              run_q, halted_q, idle_q, err_dec_q, err_slv_q, err_irq_q, fdone_q;

  // application word store
  logic              app_we;
  logic [APP_AW-1:0] app_waddr;
  logic [WORD_W-1:0] app_rdata;

  assign app_we    = (state == S_F_WAIT) && mem_rvalid && (mem_rerr == RSP_OK) &&
                     (fetch_k >= 4'(APP_FIRST));
  assign app_waddr = APP_AW'(fetch_k - 4'(APP_FIRST));

  sgw_app_ram #(.WIDTH(WORD_W), .DEPTH(N_APP)) u_app (
    .clk   (clk),
    .we    (app_we),
    .waddr (app_waddr),
    .wdata (mem_rdata),
    .raddr (app_idx),
    .rdata (app_rdata)
  );

  // byte enables for the next data beat
  logic [BYTES-1:0] keep_w;
  logic [LEN_W-1:0] take_w;
  logic             final_w;

  sgw_beat_calc #(.LEN_W(LEN_W), .BYTES(BYTES)) u_beat (
    .remain     (remain_q),
    .keep       (keep_w),
    .take       (take_w),
    .final_beat (final_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_STOP;
      cur_ptr     <= '0;
      tail_ptr    <= '0;
      nxt_ptr     <= '0;
      buf_ptr     <= '0;
      remain_q    <= '0;
      sof_q       <= 1'b0;
      eof_q       <= 1'b0;
      done_q      <= 1'b0;
      fetch_k     <= '0;
      app_idx     <= '0;
      dat_data_q  <= '0;
      dat_keep_q  <= '0;
      dat_last_q  <= 1'b0;
      mem_addr_q  <= '0;
      mem_we_q    <= 1'b0;
      mem_wdata_q <= '0;
      run_q       <= 1'b0;
      halted_q    <= 1'b1;
      idle_q      <= 1'b0;
      err_dec_q   <= 1'b0;
      err_slv_q   <= 1'b0;
      err_irq_q   <= 1'b0;
      fdone_q     <= 1'b0;
    end else begin
      fdone_q <= 1'b0;
      case (state)
        S_STOP: begin
          if (start) begin
            cur_ptr    <= cur_ptr_in;
            tail_ptr   <= tail_ptr_in;
            run_q      <= 1'b1;
            halted_q   <= 1'b0;
            idle_q     <= 1'b0;
            err_dec_q  <= 1'b0;
            err_slv_q  <= 1'b0;
            err_irq_q  <= 1'b0;
            fetch_k    <= '0;
            mem_we_q   <= 1'b0;
            mem_addr_q <= word_addr(cur_ptr_in, fetch_off(4'd0));
            state      <= S_F_REQ;
          end
        end
        S_F_REQ: if (mem_ready) state <= S_F_WAIT;
        S_F_WAIT: begin
          if (mem_rvalid) begin
            if (mem_rerr != RSP_OK) begin
              err_dec_q <= (mem_rerr == RSP_DECERR);
              err_slv_q <= (mem_rerr != RSP_DECERR);
              err_irq_q <= 1'b1;
              run_q     <= 1'b0;
              halted_q  <= 1'b1;
              state     <= S_STOP;
            end else begin
              case (fetch_k)
                4'd0: nxt_ptr <= ADDR_W'(mem_rdata);
                4'd1: buf_ptr <= ADDR_W'(mem_rdata);
                4'd2: begin
                  sof_q    <= mem_rdata[SOF_BIT];
                  eof_q    <= mem_rdata[EOF_BIT];
                  remain_q <= mem_rdata[LEN_W-1:0];
                end
                4'd3: done_q <= mem_rdata[DONE_BIT];
                default: ;
              endcase
              if (fetch_k == 4'(N_FETCH - 1)) begin
                state <= S_CHECK;
              end else begin
                fetch_k    <= fetch_k + 4'd1;
                mem_addr_q <= word_addr(cur_ptr, fetch_off(fetch_k + 4'd1));
                state      <= S_F_REQ;
              end
            end
          end
        end
        S_CHECK: begin
          if (done_q) begin
            halted_q <= 1'b1;
            state    <= S_STOP;
          end else if (sof_q) begin
            app_idx <= '0;
            state   <= S_CTL_LD;
          end else begin
            state <= S_D_NEXT;
          end
        end
        S_CTL_LD: state <= S_CTL_OUT;
        S_CTL_OUT: begin
          if (ctl_ready) begin
            if (app_idx == APP_AW'(N_APP - 1)) begin
              state <= S_D_NEXT;
            end else begin
              app_idx <= app_idx + APP_AW'(1);
              state   <= S_CTL_LD;
            end
          end
        end
        S_D_NEXT: begin
          if (remain_q == '0) begin
            mem_we_q    <= 1'b1;
            mem_addr_q  <= word_addr(cur_ptr, STATUS_WOFF);
            mem_wdata_q <= DONE_WORD;
            state       <= S_W_REQ;
          end else begin
            mem_we_q   <= 1'b0;
            mem_addr_q <= buf_ptr;
            state      <= S_D_REQ;
          end
        end
        S_D_REQ: if (mem_ready) state <= S_D_WAIT;
        S_D_WAIT: begin
          if (mem_rvalid) begin
            dat_data_q <= mem_rdata;
            dat_keep_q <= keep_w;
            dat_last_q <= eof_q && final_w;
            state      <= S_D_OUT;
          end
        end
        S_D_OUT: begin
          if (dat_ready) begin
            remain_q <= remain_q - take_w;
            buf_ptr  <= buf_ptr + ADDR_W'(BYTES);
            state    <= S_D_NEXT;
          end
        end
        S_W_REQ: if (mem_ready) state <= S_W_WAIT;
        S_W_WAIT: begin
          if (mem_rvalid) begin
            mem_we_q <= 1'b0;
            fdone_q  <= eof_q;
            cur_ptr  <= nxt_ptr;
            if (cur_ptr == tail_ptr) begin
              idle_q <= 1'b1;
              state  <= S_STOP;
            end else begin
              fetch_k    <= '0;
              mem_addr_q <= word_addr(nxt_ptr, fetch_off(4'd0));
              state      <= S_F_REQ;
            end
          end
        end
        default: state <= S_STOP;
      endcase
    end
  end

  assign mem_req    = (state == S_F_REQ) || (state == S_D_REQ) || (state == S_W_REQ);
  assign mem_we     = mem_we_q;
  assign mem_addr   = mem_addr_q;
  assign mem_wdata  = mem_wdata_q;
  assign ctl_valid  = (state == S_CTL_OUT);
  assign ctl_data   = app_rdata;
  assign ctl_last   = ctl_valid && (app_idx == APP_AW'(N_APP - 1));
  assign dat_valid  = (state == S_D_OUT);
  assign dat_data   = dat_data_q;
  assign dat_keep   = dat_keep_q;
  assign dat_last   = dat_valid && dat_last_q;
  assign running    = run_q;
  assign halted     = halted_q;
  assign idle       = idle_q;
  assign err_decode = err_dec_q;
  assign err_slave  = err_slv_q;
  assign err_irq    = err_irq_q;
  assign frame_done = fdone_q;
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              ctl_valid,
  input logic              ctl_ready,
  input logic [31:0]       ctl_data,
  input logic              dat_valid,
  input logic              dat_ready,
  input logic [31:0]       dat_data,
  input logic [3:0]        dat_keep,
  input logic              running,
  input logic              halted,
  input logic              idle,
  input logic              err_decode,
  input logic              err_slave,
  input logic              err_irq,
  input logic              frame_done
);
  a_r2_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (halted || idle) |-> !mem_req);

  a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r10_err_halts: assert property (@(posedge clk) disable iff (rst)
    $rose(err_irq) |-> (halted && !running));

  a_r10_one_err_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_decode, err_slave}));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  a_r12_streams_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ctl_valid && dat_valid));

  a_r12_dat_held: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && !dat_ready) |=> (dat_valid && $stable(dat_data) && $stable(dat_keep)));

  a_r12_ctl_held: assert property (@(posedge clk) disable iff (rst)
    (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_data)));
endmodule

bind sg_walker sg_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sg_walker_tb.sv
module sg_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SOF = 32'h0800_0000;
  localparam logic [31:0] EOF = 32'h0400_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cur_ptr_in = '0, tail_ptr_in = '0;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  mem_rerr = '0;
  logic        ctl_valid, ctl_ready, ctl_last;
  logic [31:0] ctl_data;
  logic        dat_valid, dat_ready, dat_last;
  logic [31:0] dat_data;
  logic [3:0]  dat_keep;
  logic        running, halted, idle, err_decode, err_slave, err_irq, frame_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_walker u_dut (.*);

  // ready patterns derived from a cycle counter
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_ready = (cyc % 3) != 2;
  assign ctl_ready = (cyc % 5) != 3;
  assign dat_ready = (cyc % 4) != 1;

  // memory model: one response per accepted request
  logic [31:0] mem [256];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [1:0]  err_code = 2'b00;
  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
      mem_rerr   <= 2'b00;
    end else begin
      mem_rvalid <= mem_req && mem_ready;
      mem_rerr   <= 2'b00;
      if (mem_req && mem_ready) begin
        mem_rdata <= mem[mem_addr[9:2]];
        if (!mem_we && mem_addr == err_addr) mem_rerr <= err_code;
      end
    end
  end

  // observation logs, sampled away from the active edge
  logic [31:0] ctl_log [64];  logic ctl_last_log [64];  int ctl_cyc [64];
  logic [31:0] dat_log [64];  logic dat_last_log [64];  int dat_cyc [64];
  logic [3:0]  keep_log [64];
  logic [31:0] wr_addr_log [64], wr_data_log [64], rd_addr_log [64];
  int nctl = 0, ndat = 0, nwr = 0, nrd = 0, nfd = 0, nreq = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ctl_valid && ctl_ready) begin
        ctl_log[nctl % 64] <= ctl_data; ctl_last_log[nctl % 64] <= ctl_last;
        ctl_cyc[nctl % 64] <= cyc; nctl <= nctl + 1;
      end
      if (dat_valid && dat_ready) begin
        dat_log[ndat % 64] <= dat_data; dat_last_log[ndat % 64] <= dat_last;
        keep_log[ndat % 64] <= dat_keep; dat_cyc[ndat % 64] <= cyc; ndat <= ndat + 1;
      end
      if (mem_req && mem_ready) begin
        nreq <= nreq + 1;
        if (mem_we) begin
          wr_addr_log[nwr % 64] <= mem_addr; wr_data_log[nwr % 64] <= mem_wdata; nwr <= nwr + 1;
        end else begin
          rd_addr_log[nrd % 64] <= mem_addr; nrd <= nrd + 1;
        end
      end
      if (frame_done) nfd <= nfd + 1;
    end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  int bc, bd, bw, br, bf;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt,
                          input logic [31:0] bufp, input logic [31:0] ctrl,
                          input logic [31:0] st, input logic [31:0] app0);
    for (int i = 0; i < 13; i++) mem[base[9:2] + 8'(i)] = 32'h0;
    mem[base[9:2] + 8'd0] = nxt;
    mem[base[9:2] + 8'd2] = bufp;
    mem[base[9:2] + 8'd6] = ctrl;
    mem[base[9:2] + 8'd7] = st;
    for (int i = 0; i < 5; i++) mem[base[9:2] + 8'(8 + i)] = app0 + 32'(i);
  endtask

  task automatic run_walk(input logic [31:0] cp, input logic [31:0] tp);
    bc = nctl; bd = ndat; bw = nwr; br = nrd; bf = nfd;
    @(negedge clk); start = 1'b1; cur_ptr_in = cp; tail_ptr_in = tp;
    @(negedge clk); start = 1'b0;
    for (int w = 0; w < 3000 && !(idle || halted); w++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "halted", 32'(halted), 1);
    chk("R1", "idle|running|errs", {27'd0, idle, running, err_decode, err_slave, err_irq}, 0);
    chk("R1", "req|ctl|dat|fdone", {28'd0, mem_req, ctl_valid, dat_valid, frame_done}, 0);
  endtask

  task automatic t_single;
    for (int i = 0; i < 3; i++) mem[i] = 32'hB000_0000 + 32'(i);
    put_desc(32'h100, 32'h3C0, 32'h000, SOF | EOF | 32'd10, 32'h0, 32'hA000);
    run_walk(32'h100, 32'h100);
    for (int i = 0; i < 9; i++)
      chk("R3", "fetch addr", rd_addr_log[(br + i) % 64],
          32'h100 + ((i < 4) ? ((i == 0) ? 0 : (i == 1) ? 8 : (i == 2) ? 24 : 28) : 32'(16 + 4 * i)));
    chk("R5", "ctl beats", 32'(nctl - bc), 5);
    for (int i = 0; i < 5; i++) begin
      chk("R5", "app word", ctl_log[(bc + i) % 64], 32'hA000 + 32'(i));
      chk("R5", "ctl_last", 32'(ctl_last_log[(bc + i) % 64]), 32'(i == 4));
    end
    chk("R5", "ctl before data", 32'(ctl_cyc[(bc + 4) % 64] < dat_cyc[bd % 64]), 1);
    chk("R6", "data beats", 32'(ndat - bd), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R6", "data word", dat_log[(bd + i) % 64], 32'hB000_0000 + 32'(i));
      chk("R6", "keep", 32'(keep_log[(bd + i) % 64]), (i == 2) ? 32'h3 : 32'hF);
      chk("R7", "last", 32'(dat_last_log[(bd + i) % 64]), 32'(i == 2));
    end
    chk("R8", "writes", 32'(nwr - bw), 1);
    chk("R8", "wb addr", wr_addr_log[bw % 64], 32'h11C);
    chk("R8", "wb data", wr_data_log[bw % 64], 32'h8000_0000);
    chk("R11", "frame_done", 32'(nfd - bf), 1);
    chk("R9", "idle/halted/running", {29'd0, idle, halted, running}, 32'b101);
  endtask

  task automatic t_chain;
    mem[32'h40 >> 2] = 32'hC0; mem[(32'h40 >> 2) + 1] = 32'hC1; mem[32'h80 >> 2] = 32'hD0;
    put_desc(32'h140, 32'h180, 32'h040, SOF | 32'd8, 32'h0, 32'hA100);
    put_desc(32'h180, 32'h1C0, 32'h080, EOF | 32'd4, 32'h0, 32'hA200);
    put_desc(32'h1C0, 32'h100, 32'h000, SOF | EOF, 32'h0, 32'hA300);
    run_walk(32'h140, 32'h180);
    chk("R5", "chain ctl beats", 32'(nctl - bc), 5);
    chk("R5", "chain app0", ctl_log[bc % 64], 32'hA100);
    chk("R6", "chain data beats", 32'(ndat - bd), 3);
    chk("R6", "chain word2", dat_log[(bd + 2) % 64], 32'hD0);
    chk("R7", "no last mid-frame", {30'd0, dat_last_log[bd % 64], dat_last_log[(bd + 1) % 64]}, 0);
    chk("R7", "last on eof desc", 32'(dat_last_log[(bd + 2) % 64]), 1);
    chk("R9", "chain writes stop at tail", 32'(nwr - bw), 2);
    chk("R9", "second wb addr", wr_addr_log[(bw + 1) % 64], 32'h19C);
    chk("R11", "one frame", 32'(nfd - bf), 1);
    chk("R9", "idle", 32'(idle), 1);
    run_walk(32'h1C0, 32'h1C0);
    chk("R6", "zero length no data", 32'(ndat - bd), 0);
    chk("R5", "zero length ctl", 32'(nctl - bc), 5);
    chk("R8", "zero length wb", wr_addr_log[bw % 64], 32'h1DC);
    chk("R11", "zero length frame", 32'(nfd - bf), 1);
  endtask

  task automatic t_complete;
    put_desc(32'h200, 32'h100, 32'h000, SOF | EOF | 32'd4, 32'h8000_0005, 32'hA400);
    run_walk(32'h200, 32'h200);
    chk("R4", "halted/idle/running", {29'd0, halted, idle, running}, 32'b101);
    chk("R4", "no beats", 32'((nctl - bc) + (ndat - bd)), 0);
    chk("R4", "no write", 32'(nwr - bw), 0);
    chk("R4", "no frame", 32'(nfd - bf), 0);
  endtask

  task automatic t_error(input logic [1:0] code, input logic [31:0] base, input logic [31:0] ea);
    put_desc(base, 32'h100, 32'h000, SOF | EOF | 32'd4, 32'h0, 32'hA500);
    err_addr = ea; err_code = code;
    run_walk(base, base);
    err_addr = 32'hFFFF_FFFF; err_code = 2'b00;
    chk("R10", "err flags dec/slv", {30'd0, err_decode, err_slave},
        (code == 2'b10) ? 32'b10 : 32'b01);
    chk("R10", "irq/halted/running", {29'd0, err_irq, halted, running}, 32'b110);
    chk("R10", "no write", 32'(nwr - bw), 0);
    chk("R10", "no beats", 32'((nctl - bc) + (ndat - bd)), 0);
  endtask

  task automatic t_quiet_and_restart;
    int q;
    q = nreq;
    repeat (30) @(negedge clk);
    chk("R2", "no requests while stopped", 32'(nreq - q), 0);
    run_walk(32'h100, 32'h100);
    chk("R2", "restart clears errors", {29'd0, err_decode, err_slave, err_irq}, 0);
    chk("R2", "restart reaches idle", {30'd0, idle, halted}, 32'b10);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_single();
    t_chain();
    t_complete();
    t_error(2'b10, 32'h240, 32'h258);
    t_error(2'b01, 32'h280, 32'h2A0);
    t_quiet_and_restart();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule